// File: doc/BRIEF.md
# Configurable SPI Master Byte Port

This block is a single-lane SPI master. A byte written to it goes out on MOSI, most significant bit first. In the same eight bit periods, eight bits are gathered from MISO. Three control inputs set the clock format:

- A polarity bit sets the idle level of SCK.
- An edge bit is the inverse of CPHA and sets which SCK edge launches data.
- A sample-phase bit moves the MISO capture point to the middle or to the end of each bit time.

An enable input gates the whole port. A rate select gives a bit period of four or sixteen system clocks.

Software-style logic drives the control inputs and pulses a write strobe with the byte. It then waits for a one-cycle done pulse, which comes with the received byte. The clock format and the rate are captured when a transfer begins. Later changes to these inputs therefore apply only to the next byte.

Top module: `spi_master_port`

## Requirements
- R1: While rst_ni is low and just after it rises, busy_o and done_o are 0, rdata_o is 0x00, and sck_o equals cpol_i.
- R2: While no transfer runs, sck_o equals cpol_i. With cpol_i=1 the SCK waveform during a transfer is the bitwise inverse of the one produced with cpol_i=0.
- R3: The edge bit edge_i is the inverse of CPHA. Mode 0 is cpol 0/edge 1, mode 1 is 0/0, mode 2 is 1/1 and mode 3 is 1/0. With edge_i=1, SCK sits at its idle level for the first half of each bit period and at the opposite level for the second half. With edge_i=0 the two halves are swapped.
- R4: MOSI carries the written byte MSB first. Each bit is held for one full bit period, and the first bit starts in the first cycle after the write. With edge_i=1 this places each bit on the line before the first SCK edge of its bit period.
- R5: With smp_i=0, MISO is captured in the last system-clock cycle of the first half of each bit period. With smp_i=1 it is captured in the last cycle of the bit period. Bits are assembled MSB first.
- R6: A write while en_i=0 starts nothing. Lowering en_i during a transfer clears busy_o at the next clock edge, returns SCK to idle and produces no done pulse.
- R7: rate_i=0 selects a bit period of 4 system clocks and rate_i=1 selects 16.
- R8: A write while idle and enabled sets busy_o at the next edge. After 8 bit periods, busy_o falls and done_o is 1 for exactly one cycle, and rdata_o holds the received byte from then on.
- R9: A write made while busy_o is 1, including in the last cycle of a transfer, has no effect on MOSI, SCK or rdata_o.
- R10: cpol_i, edge_i, smp_i and rate_i are captured at the start of a transfer. Changes made during a transfer do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| cpol_i | input | 1 | SCK idle level |
| edge_i | input | 1 | Clock-edge select (inverse of CPHA) |
| smp_i | input | 1 | MISO sample point: 0 middle, 1 end of bit |
| rate_i | input | 1 | Bit period: 0 is 4 clocks, 1 is 16 clocks |
| wr_i | input | 1 | Write strobe for wdata_i |
| wdata_i | input | 8 | Byte to transmit |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| rdata_o | output | 8 | Last received byte |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Two events can fall in the same cycle: the end of a transfer and a new write that arrives while busy_o is still 1. The bench provokes this by pulsing the write strobe in the final cycle of a transfer, and in other cycles, with a different byte. It then checks that done_o still pulses, that rdata_o holds the expected byte and that no second transfer begins. The bench also changes edge, sample-phase and rate in mid-transfer, and checks every cycle of SCK and MOSI against the waveform computed from the settings that were captured at the start. MISO is driven with different values in the two halves of each bit, so the byte received shows which capture point was used.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic smp_end;
    logic slow;
  } spi_cfg_t;
endpackage

// File: rtl/spi_bit_timer.sv
`timescale 1ns/1ps
module spi_bit_timer #(
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_SLOW = 16,
  parameter int unsigned BITS     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic slow_i,
  output logic half_o,
  output logic mid_o,
  output logic bit_end_o,
  output logic last_bit_o
);
  localparam int unsigned CNT_W = $clog2(DIV_SLOW);
  localparam int unsigned BIT_W = $clog2(BITS);

  logic [CNT_W-1:0] cnt_q, lim, hlf;
  logic [BIT_W-1:0] bit_q;

  assign lim        = slow_i ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
  assign hlf        = slow_i ? CNT_W'(DIV_SLOW / 2) : CNT_W'(DIV_FAST / 2);
  assign half_o     = cnt_q >= hlf;
  assign mid_o      = cnt_q == (hlf - CNT_W'(1));
  assign bit_end_o  = cnt_q == lim;
  assign last_bit_o = bit_q == BIT_W'(BITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bit_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      bit_q <= '0;
    end else if (run_i) begin
      if (bit_end_o) begin
        cnt_q <= '0;
        bit_q <= bit_q + BIT_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= lim); // R7
  AST_BIT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !start_i && bit_end_o && !last_bit_o |=> bit_q == $past(bit_q) + BIT_W'(1)); // R8
endmodule

// File: rtl/spi_clk_shaper.sv
`timescale 1ns/1ps
module spi_clk_shaper (
  input  logic run_i,
  input  logic idle_pol_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic smp_end_i,
  input  logic half_i,
  input  logic mid_i,
  input  logic bit_end_i,
  output logic sck_o,
  output logic sample_o
);
  logic active;

  // cpha=0: active in second half; cpha=1: active in first half
  assign active   = cpha_i ? ~half_i : half_i;
  assign sck_o    = run_i ? (cpol_i ^ active) : idle_pol_i;
  assign sample_o = run_i & (smp_end_i ? bit_end_i : mid_i);
endmodule

// File: rtl/spi_shift_unit.sv
`timescale 1ns/1ps
module spi_shift_unit #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [WIDTH-1:0] rx_next_o
);
  logic [WIDTH-1:0] tx_q, rx_q;

  assign mosi_o    = tx_q[WIDTH-1];
  assign rx_next_o = sample_i ? {rx_q[WIDTH-2:0], miso_i} : rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= data_i;
      rx_q <= '0;
    end else begin
      if (shift_i) tx_q <= {tx_q[WIDTH-2:0], 1'b0};
      rx_q <= rx_next_o;
    end
  end

  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !shift_i |=> $stable(mosi_o)); // R4
endmodule

// File: rtl/spi_master_port.sv
`timescale 1ns/1ps
module spi_master_port #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_SLOW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              edge_i,
  input  logic              smp_i,
  input  logic              rate_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  import spi_port_pkg::*;

  spi_cfg_t          cfg_q;
  logic              busy_q, done_q;
  logic [BYTE_W-1:0] rdata_q, rx_next;
  logic              start, finish, half, mid, bit_end, last_bit, sample;

  assign start  = wr_i & en_i & ~busy_q;
  assign finish = busy_q & en_i & bit_end & last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      cfg_q   <= '0;
    end else begin
      done_q <= finish;
      if (!en_i) begin
        busy_q <= 1'b0;
      end else if (start) begin
        busy_q <= 1'b1;
        cfg_q  <= '{cpol: cpol_i, cpha: ~edge_i, smp_end: smp_i, slow: rate_i};
      end else if (finish) begin
        busy_q  <= 1'b0;
        rdata_q <= rx_next;
      end
    end
  end

  spi_bit_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .BITS(BYTE_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .run_i(busy_q),
    .slow_i(cfg_q.slow), .half_o(half), .mid_o(mid), .bit_end_o(bit_end),
    .last_bit_o(last_bit)
  );

  spi_clk_shaper u_shaper (
    .run_i(busy_q), .idle_pol_i(cpol_i), .cpol_i(cfg_q.cpol), .cpha_i(cfg_q.cpha),
    .smp_end_i(cfg_q.smp_end), .half_i(half), .mid_i(mid), .bit_end_i(bit_end),
    .sck_o(sck_o), .sample_o(sample)
  );

  spi_shift_unit #(.WIDTH(BYTE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start), .data_i(wdata_i),
    .shift_i(busy_q & bit_end & ~last_bit), .sample_i(sample), .miso_i(miso_i),
    .mosi_o(mosi_o), .rx_next_o(rx_next)
  );

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R8
  AST_OFF_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o && !done_o); // R6
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(cfg_q)); // R10
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && en_i && !finish |=> busy_q && $stable(rdata_q)); // R9
endmodule

// File: tb/spi_master_port_tb_top.sv
`timescale 1ns/1ps
module spi_master_port_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       en_i = 1'b1, cpol_i = 1'b0, edge_i = 1'b1, smp_i = 1'b0, rate_i = 1'b0;
  logic       wr_i = 1'b0, miso_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       busy_o, done_o, sck_o, mosi_o;
  logic [7:0] rdata_o;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  spi_master_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cpol_i(cpol_i), .edge_i(edge_i),
    .smp_i(smp_i), .rate_i(rate_i), .wr_i(wr_i), .wdata_i(wdata_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_sck(input logic cp, input logic ed, input int ph, input int dv);
    logic act;
    act = ed ? (ph >= dv / 2) : (ph < dv / 2);
    return cp ^ act;
  endfunction

  // one transfer; junk_at = cycle of an ignored write (-1 none); flip = change cfg mid-transfer
  task automatic xfer(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b,
                      input logic cp, input logic ed, input logic sm, input logic rt,
                      input int junk_at, input bit flip);
    int dv;
    logic [7:0] exp_rx;
    dv = rt ? 16 : 4;
    exp_rx = sm ? b : a;
    @(negedge clk_i);
    cpol_i = cp; edge_i = ed; smp_i = sm; rate_i = rt; wdata_i = tx; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    for (int j = 0; j < 8 * dv; j++) begin
      int bi, ph;
      bi = j / dv; ph = j % dv;
      miso_i = (ph < dv / 2) ? a[7-bi] : b[7-bi];
      wr_i = (j == junk_at);
      wdata_i = ~tx;
      if (flip && j == dv + 1) begin
        edge_i = ~ed; smp_i = ~sm; rate_i = ~rt; // R10
      end
      #1;
      chk(busy_o == 1'b1, "R8", "busy", int'(busy_o), 1);
      chk(sck_o == exp_sck(cp, ed, ph, dv), "R3", "sck", int'(sck_o), int'(exp_sck(cp, ed, ph, dv)));
      chk(mosi_o == tx[7-bi], "R4", "mosi", int'(mosi_o), int'(tx[7-bi]));
      @(negedge clk_i);
    end
    wr_i = 1'b0;
    #1;
    chk(done_o == 1'b1, "R8", "done", int'(done_o), 1);
    chk(busy_o == 1'b0, "R8", "busy end", int'(busy_o), 0);
    chk(rdata_o == exp_rx, "R5", "rdata", int'(rdata_o), int'(exp_rx));
    chk(sck_o == cp, "R2", "idle sck", int'(sck_o), int'(cp));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8", "done pulse", int'(done_o), 0);
    chk(busy_o == 1'b0, "R9", "no restart", int'(busy_o), 0);
    chk(rdata_o == exp_rx, "R9", "rdata hold", int'(rdata_o), int'(exp_rx));
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL R8 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(busy_o == 0 && done_o == 0, "R1", "reset flags", {busy_o, done_o}, 0);
    chk(rdata_o == 8'h00, "R1", "reset rdata", int'(rdata_o), 0);
    chk(sck_o == cpol_i, "R1", "reset sck", int'(sck_o), int'(cpol_i));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cpol_i = 1'b1; #1;
    chk(sck_o == 1'b1, "R2", "idle sck high", int'(sck_o), 1);
    // four modes, both rates, both sample points (R3 R7 R5)
    xfer(8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, -1, 1'b0);
    xfer(8'h5A, 8'h96, 8'h69, 1'b0, 1'b0, 1'b1, 1'b1, -1, 1'b0);
    xfer(8'hF0, 8'h0F, 8'hE1, 1'b1, 1'b1, 1'b1, 1'b0, -1, 1'b0);
    xfer(8'h81, 8'h7E, 8'h18, 1'b1, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    // write in last cycle and mid-transfer while busy (R9), cfg change mid-transfer (R10)
    xfer(8'hC6, 8'h55, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b0, 31, 1'b0);
    xfer(8'h3B, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 9, 1'b1);
    xfer(8'h00, 8'h12, 8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1'b1);
    // disabled write (R6)
    @(negedge clk_i);
    en_i = 1'b0; cpol_i = 1'b0; wdata_i = 8'h77; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; #1;
    chk(busy_o == 1'b0, "R6", "disabled write", int'(busy_o), 0);
    chk(mosi_o == 1'b0, "R6", "disabled mosi", int'(mosi_o), 0);
    // abort by lowering enable (R6)
    en_i = 1'b1; cpol_i = 1'b1; edge_i = 1'b1; rate_i = 1'b1; wdata_i = 8'hFF; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; #1;
    chk(busy_o == 1'b1, "R8", "start", int'(busy_o), 1);
    repeat (9) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i); #1;
    chk(busy_o == 1'b0, "R6", "abort busy", int'(busy_o), 0);
    chk(sck_o == 1'b1, "R6", "abort sck idle", int'(sck_o), 1);
    for (int k = 0; k < 20; k++) begin
      chk(done_o == 1'b0, "R6", "no done after abort", int'(done_o), 0);
      @(negedge clk_i);
    end
    en_i = 1'b1;
    // constrained random
    for (int n = 0; n < 16; n++) begin
      logic [7:0] t, a, b;
      logic [3:0] c;
      t = 8'($urandom); a = 8'($urandom); b = 8'($urandom); c = 4'($urandom);
      xfer(t, a, b, c[0], c[1], c[2], c[3], (n % 3 == 0) ? int'($urandom % 32) : -1, n[0]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule